// File: doc/BRIEF.md
# Four-Channel Digital Potentiometer Serial Command Controller

This block is the digital heart of a four-channel digital potentiometer. It is a slave on a two-wire serial bus (clock and open-drain data, I2C-like). Four pin-strapped inputs complete its device address. Each transaction is short and fixed in shape: a start, an address byte, a one-byte command, one data byte, then a stop. The command either reads or writes the live wiper setting of one channel, or reads or writes one of four stored settings kept for that channel. The block drives a tap-select word for each of the four channels.

Stored settings stand in for nonvolatile cells. They are plain flops that keep their contents through reset. When reset is released, each channel's wiper is restored from its first stored setting. A write to a stored setting does not take effect at once. It is committed at the stop condition, and a programming timer then runs for a parameterised number of system clocks. While the timer runs, the block leaves the data line released and will not acknowledge even its own address. Both bus lines pass through a two-flop synchronizer, so the system clock must run several times faster than the bus clock.

Top module: `quad_pot_ctrl`

## Requirements
- R1: The address byte is acknowledged only when it equals binary 0101 followed by `dev_pins[3:0]` (MSB first). The pattern has no direction bit. Any other address byte is answered with NACK.
- R2: In the command byte, bits 7:4 select the operation: 1001 reads a wiper, 1010 writes a wiper, 1011 reads a stored setting, 1100 writes a stored setting. Any other value in bits 7:4 gets NACK on the command byte.
- R3: A wiper write changes `wiper_taps[6*P +: 6]` at the end of the data byte's acknowledge clock, where P is command bits 3:2. It does not start the programming timer, so `busy` stays low.
- R4: Only data bits 5:0 carry a setting, and bits 7:6 are ignored on writes. Every read returns bits 7:6 as zero.
- R5: A wiper read shifts out the channel's current setting MSB first, one bit per bus clock low phase. After the eighth bit the data line is released.
- R6: The sixteen stored settings are addressed by channel (command bits 3:2) and slot (command bits 1:0). A stored write leaves every wiper output unchanged. The stored value can be read back, and it survives a reset.
- R7: The stop that ends a stored-setting write raises `busy` for `WR_CYCLES` system clocks.
- R8: While `busy` is high, the block never pulls the data line low and does not acknowledge a matching address.
- R9: While reset is asserted, `busy` is low, the data line is released and the wiper outputs are zero. After release, each channel's wiper takes the value of that channel's slot 0.
- R10: After a NACK, the block ignores all further bus bits until the next start condition. No output or register changes in that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Serial bus clock line |
| sda_in | input | 1 | Serial bus data line as seen on the wire |
| dev_pins | input | 4 | Strapped low bits of the device address |
| sda_pull | output | 1 | High to pull the open-drain data line low |
| wiper_taps | output | 24 | Tap select, channel N in bits 6N+5:6N |
| busy | output | 1 | Programming timer running |

## Verification
A vector table runs write and read commands over every channel and several slots. It mixes patterns whose bits 7:6 are set with patterns whose bits 7:6 are clear, which separates a correct 6-bit datapath from one that passes or mirrors the top bits. The table also uses channel and slot codes whose two bits differ, so a swapped or shifted field shows up as the wrong channel or slot changing. Directed cases apply a wrong address, an invalid opcode and an address sent while busy. Each is followed by a check of the outputs and a read-back, which shows whether the ignored bytes touched anything. A reset after distinct slot-0 values are loaded shows whether the recall reaches the right channel.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int unsigned POT_SEL_BITS  = 2;
  localparam int unsigned SLOT_SEL_BITS = 2;
  localparam int unsigned NUM_POTS      = 1 << POT_SEL_BITS;
  localparam int unsigned NUM_SLOTS     = 1 << SLOT_SEL_BITS;
  localparam int unsigned BYTE_BITS     = 8;
  localparam logic [3:0]  DEV_PREFIX    = 4'b0101;

  typedef enum logic [3:0] {
    OP_RD_WIPER = 4'b1001,
    OP_WR_WIPER = 4'b1010,
    OP_RD_SLOT  = 4'b1011,
    OP_WR_SLOT  = 4'b1100
  } opcode_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_INSTR,
    S_INSTR_ACK,
    S_WDATA,
    S_WDATA_ACK,
    S_RDATA,
    S_HOLD
  } bus_state_e;
endpackage

// File: rtl/qpc_bus_sync.sv
module qpc_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/qpc_busy_timer.sv
module qpc_busy_timer #(
  parameter int unsigned WR_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int unsigned CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = CW'(WR_CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  a_r7_load_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
  a_r7_no_reload_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load);
endmodule

// File: rtl/qpc_reg_bank.sv
module qpc_reg_bank import qpc_pkg::*; #(
  parameter int unsigned TAP_BITS = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wiper_we,
  input  logic                          slot_we,
  input  logic [POT_SEL_BITS-1:0]       sel_pot,
  input  logic [SLOT_SEL_BITS-1:0]      sel_slot,
  input  logic                          rd_from_slot,
  input  logic [TAP_BITS-1:0]           wdata,
  output logic [TAP_BITS-1:0]           rd_value,
  output logic [NUM_POTS*TAP_BITS-1:0]  taps
);
  logic [TAP_BITS-1:0] slot_q  [NUM_POTS][NUM_SLOTS];
  logic [TAP_BITS-1:0] wiper_q [NUM_POTS];
  logic [TAP_BITS-1:0] wiper_d [NUM_POTS];
  logic                recall_q;

  // Stored settings model nonvolatile cells: no reset, kept across rst_n.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_POTS; p++) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (slot_we && (sel_pot == POT_SEL_BITS'(p)) && (sel_slot == SLOT_SEL_BITS'(s)))
          slot_q[p][s] <= wdata;
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_POTS; p++) begin
      if (recall_q)
        wiper_d[p] = slot_q[p][0];
      else if (wiper_we && (sel_pot == POT_SEL_BITS'(p)))
        wiper_d[p] = wdata;
      else
        wiper_d[p] = wiper_q[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recall_q <= 1'b1;
      for (int p = 0; p < NUM_POTS; p++) wiper_q[p] <= '0;
    end else begin
      recall_q <= 1'b0;
      for (int p = 0; p < NUM_POTS; p++) wiper_q[p] <= wiper_d[p];
    end
  end

  assign rd_value = rd_from_slot ? slot_q[sel_pot][sel_slot] : wiper_q[sel_pot];

  for (genvar g = 0; g < NUM_POTS; g++) begin : g_tap
    assign taps[g*TAP_BITS +: TAP_BITS] = wiper_q[g];

    a_r9_recall_slot0: assert property (@(posedge clk) disable iff (!rst_n)
      recall_q |=> (wiper_q[g] == $past(slot_q[g][0])));
  end

  a_r6_slot_write_keeps_taps: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_we && !recall_q) |=> (taps == $past(taps)));
endmodule

// File: rtl/qpc_serial_fsm.sv
module qpc_serial_fsm import qpc_pkg::*; #(
  parameter int unsigned TAP_BITS = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busy,
  input  logic [3:0]               dev_pins,
  input  logic                     sda_s,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_det,
  input  logic                     stop_det,
  input  logic [TAP_BITS-1:0]      rd_value,
  output logic                     sda_pull,
  output logic                     wiper_we,
  output logic                     slot_we,
  output logic                     timer_load,
  output logic [POT_SEL_BITS-1:0]  sel_pot,
  output logic [SLOT_SEL_BITS-1:0] sel_slot,
  output logic                     rd_from_slot,
  output logic [TAP_BITS-1:0]      wdata
);
  localparam int unsigned PAD = BYTE_BITS - TAP_BITS;

  bus_state_e          state_q, state_d;
  logic [3:0]          cnt_q, cnt_d;
  logic [7:0]          sh_q, sh_d;
  logic [7:0]          instr_q, instr_d;
  logic [TAP_BITS-1:0] wdata_q, wdata_d;
  logic                pend_q, pend_d;
  logic                byte_done;
  logic                op_is_read;

  assign op_is_read = (instr_q[7:4] == OP_RD_WIPER) || (instr_q[7:4] == OP_RD_SLOT);
  assign byte_done  = scl_fall && (cnt_q == 4'd8);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    instr_d    = instr_q;
    wdata_d    = wdata_q;
    pend_d     = pend_q;
    wiper_we   = 1'b0;
    slot_we    = 1'b0;
    timer_load = 1'b0;
    if (busy) begin
      state_d = S_IDLE;
      pend_d  = 1'b0;
    end else if (start_det) begin
      state_d = S_ADDR;
      cnt_d   = '0;
      pend_d  = 1'b0;
    end else if (stop_det) begin
      if (pend_q) begin
        slot_we    = 1'b1;
        timer_load = 1'b1;
      end
      pend_d  = 1'b0;
      state_d = S_IDLE;
    end else begin
      case (state_q)
        S_ADDR, S_INSTR, S_WDATA: begin
          if (scl_rise && (cnt_q != 4'd8)) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (byte_done) begin
            cnt_d = '0;
            if (state_q == S_ADDR) begin
              state_d = (sh_q == {DEV_PREFIX, dev_pins}) ? S_ADDR_ACK : S_HOLD;
            end else if (state_q == S_INSTR) begin
              if (sh_q[7:4] inside {OP_RD_WIPER, OP_WR_WIPER, OP_RD_SLOT, OP_WR_SLOT}) begin
                instr_d = sh_q;
                state_d = S_INSTR_ACK;
              end else begin
                state_d = S_HOLD;
              end
            end else begin
              wdata_d = sh_q[TAP_BITS-1:0];
              pend_d  = (instr_q[7:4] == OP_WR_SLOT);
              state_d = S_WDATA_ACK;
            end
          end
        end
        S_ADDR_ACK: begin
          if (scl_fall) state_d = S_INSTR;
        end
        S_INSTR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (op_is_read) begin
              state_d = S_RDATA;
              sh_d    = {{PAD{1'b0}}, rd_value};
            end else begin
              state_d = S_WDATA;
            end
          end
        end
        S_WDATA_ACK: begin
          if (scl_fall) begin
            wiper_we = (instr_q[7:4] == OP_WR_WIPER);
            state_d  = S_HOLD;
          end
        end
        S_RDATA: begin
          if (scl_fall) begin
            sh_d  = {sh_q[6:0], 1'b0};
            cnt_d = cnt_q + 4'd1;
            if (cnt_q == 4'd7) state_d = S_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      instr_q <= '0;
      wdata_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      instr_q <= instr_d;
      wdata_q <= wdata_d;
      pend_q  <= pend_d;
    end
  end

  always_comb begin
    case (state_q)
      S_ADDR_ACK, S_INSTR_ACK, S_WDATA_ACK: sda_pull = 1'b1;
      S_RDATA:                              sda_pull = ~sh_q[7];
      default:                              sda_pull = 1'b0;
    endcase
  end

  assign sel_pot      = instr_q[3:2];
  assign sel_slot     = instr_q[1:0];
  assign rd_from_slot = (instr_q[7:4] == OP_RD_SLOT);
  assign wdata        = wdata_q;

  a_r8_silent_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);
  a_r3_wiper_write_no_timer: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_we |-> !timer_load);
  a_r10_hold_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HOLD && !start_det && !stop_det) |=> (state_q == S_HOLD && !wiper_we));
endmodule

// File: rtl/quad_pot_ctrl.sv
module quad_pot_ctrl import qpc_pkg::*; #(
  parameter int unsigned TAP_BITS    = 6,
  parameter int unsigned WR_CYCLES   = 1000000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scl_in,
  input  logic                         sda_in,
  input  logic [3:0]                   dev_pins,
  output logic                         sda_pull,
  output logic [NUM_POTS*TAP_BITS-1:0] wiper_taps,
  output logic                         busy
);
  logic [1:0]               rst_q;
  logic                     rst_sync_n;
  logic                     sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic                     wiper_we, slot_we, timer_load, rd_from_slot;
  logic [POT_SEL_BITS-1:0]  sel_pot;
  logic [SLOT_SEL_BITS-1:0] sel_slot;
  logic [TAP_BITS-1:0]      wdata, rd_value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  qpc_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  qpc_serial_fsm #(.TAP_BITS(TAP_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .busy(busy), .dev_pins(dev_pins),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_value(rd_value),
    .sda_pull(sda_pull), .wiper_we(wiper_we), .slot_we(slot_we),
    .timer_load(timer_load), .sel_pot(sel_pot), .sel_slot(sel_slot),
    .rd_from_slot(rd_from_slot), .wdata(wdata)
  );

  qpc_reg_bank #(.TAP_BITS(TAP_BITS)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wiper_we(wiper_we), .slot_we(slot_we),
    .sel_pot(sel_pot), .sel_slot(sel_slot), .rd_from_slot(rd_from_slot),
    .wdata(wdata), .rd_value(rd_value), .taps(wiper_taps)
  );

  qpc_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .load(timer_load), .busy(busy)
  );

  a_r3_no_joint_writes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wiper_we && slot_we));
endmodule

// File: tb/quad_pot_ctrl_test.sv
module quad_pot_ctrl_test;
  localparam int WR = 1000;
  localparam int Q  = 4;
  localparam logic [3:0] PINS = 4'b1010;
  localparam logic [7:0] ADDR = 8'h5A;
  localparam int NV = 18;
  // {command, data}; for reads the data field holds the expected byte
  localparam logic [15:0] VEC [NV] = '{
    16'hA0_2A, 16'hAC_FF, 16'hA4_19, 16'h9C_3F, 16'h90_2A, 16'h94_19,
    16'hC6_15, 16'hC4_33, 16'hCB_3E, 16'hC9_C2, 16'hC0_07, 16'hC8_11,
    16'hCC_01, 16'hB6_15, 16'hB4_33, 16'hBB_3E, 16'hB9_02, 16'hB0_07
  };

  logic        clk = 1'b0;
  logic        rst_n, scl_m, sda_m, sda_line;
  logic        sda_pull, busy;
  logic [23:0] wiper_taps;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  quad_pot_ctrl #(.WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .dev_pins(PINS), .sda_pull(sda_pull), .wiper_taps(wiper_taps), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [5:0] tap(input int p);
    return wiper_taps[p*6 +: 6];
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    tick(Q); sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0;
  endtask

  task automatic sample_bit(output logic v);
    tick(Q); sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    v = sda_line; tick(Q);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sample_bit(v);
    ack = !v;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    logic v;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      sample_bit(v);
      d = {d[6:0], v};
    end
    send_bit(1'b1);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] ins, input logic [7:0] dat,
                          output logic [2:0] acks);
    bus_start();
    send_byte(a, acks[2]);
    send_byte(ins, acks[1]);
    send_byte(dat, acks[0]);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] a, input logic [7:0] ins,
                         output logic [1:0] acks, output logic [7:0] d);
    bus_start();
    send_byte(a, acks[1]);
    send_byte(ins, acks[0]);
    recv_byte(d);
    bus_stop();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 4*WR) begin
      tick(1);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0]  wa;
    logic [1:0]  ra;
    logic [7:0]  rd, ins, dat;
    logic [23:0] taps_before;
    int          n;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    tick(10);
    // R9: outputs during reset
    check(busy == 1'b0, "R9 busy in reset", busy, 0);
    check(sda_pull == 1'b0, "R9 data line released in reset", sda_pull, 0);
    check(wiper_taps == 24'h0, "R9 taps zero in reset", wiper_taps, 0);
    rst_n = 1'b1;
    tick(10);

    for (int i = 0; i < NV; i++) begin
      ins = VEC[i][15:8];
      dat = VEC[i][7:0];
      if (ins[7:4] == 4'h9 || ins[7:4] == 4'hB) begin
        do_read(ADDR, ins, ra, rd);
        check(ra == 2'b11, "R1 R2 acks on read", ra, 3);
        check(rd == dat, "R5 R6 R4 read value", rd, dat);
      end else begin
        taps_before = wiper_taps;
        do_write(ADDR, ins, dat, wa);
        check(wa == 3'b111, "R1 R2 acks on write", wa, 7);
        if (ins[7:4] == 4'hA) begin
          check(tap(ins[3:2]) == dat[5:0], "R3 R4 wiper tap updated", tap(ins[3:2]), dat[5:0]);
          check(busy == 1'b0, "R3 wiper write leaves busy low", busy, 0);
        end else begin
          check(busy == 1'b1, "R7 busy after stored write", busy, 1);
          check(wiper_taps == taps_before, "R6 stored write keeps taps", wiper_taps, taps_before);
          wait_idle(n);
          tick(4);
        end
      end
    end

    // R8: a stored write, then an address while busy
    do_write(ADDR, 8'hCD, 8'h2C, wa);
    do_read(ADDR, 8'h9C, ra, rd);
    check(ra == 2'b00, "R8 no ack while busy", ra, 0);
    check(rd == 8'hFF, "R8 line released while busy", rd, 8'hFF);
    check(busy == 1'b1, "R7 still busy within window", busy, 1);
    wait_idle(n);
    tick(4);

    // R7: length of the programming window
    do_write(ADDR, 8'hCE, 8'h05, wa);
    wait_idle(n);
    check(n >= WR - 20 && n <= WR, "R7 busy length", n, WR);
    tick(4);
    do_read(ADDR, 8'hBD, ra, rd);
    check(rd == 8'h2C, "R6 slot p3 s1", rd, 8'h2C);
    do_read(ADDR, 8'hBE, ra, rd);
    check(rd == 8'h05, "R6 slot p3 s2", rd, 8'h05);

    // R1 R10: wrong address ignored
    taps_before = wiper_taps;
    do_write(8'h5B, 8'hA0, 8'h3F, wa);
    check(wa == 3'b000, "R1 R10 wrong address nack", wa, 0);
    check(wiper_taps == taps_before, "R10 taps unchanged after bad address", wiper_taps, taps_before);
    do_write(8'h4A, 8'hC0, 8'h3F, wa);
    check(wa == 3'b000, "R1 wrong prefix nack", wa, 0);
    check(busy == 1'b0, "R10 no busy after bad address", busy, 0);

    // R2 R10: invalid opcodes
    do_write(ADDR, 8'hD0, 8'h3F, wa);
    check(wa == 3'b100, "R2 opcode 1101 nack", wa, 4);
    check(wiper_taps == taps_before, "R10 taps unchanged after bad opcode", wiper_taps, taps_before);
    do_write(ADDR, 8'h80, 8'h3F, wa);
    check(wa == 3'b100, "R2 opcode 1000 nack", wa, 4);
    check(busy == 1'b0, "R10 no busy after bad opcode", busy, 0);
    do_read(ADDR, 8'hB0, ra, rd);
    check(rd == 8'h07, "R10 slot p0 s0 untouched", rd, 8'h07);

    // R9 R6: recall after reset, stored values retained
    rst_n = 1'b0;
    tick(4);
    check(wiper_taps == 24'h0, "R9 taps zero in reset", wiper_taps, 0);
    rst_n = 1'b1;
    tick(10);
    check(tap(0) == 6'h07, "R9 recall p0", tap(0), 6'h07);
    check(tap(1) == 6'h33, "R9 recall p1", tap(1), 6'h33);
    check(tap(2) == 6'h11, "R9 recall p2", tap(2), 6'h11);
    check(tap(3) == 6'h01, "R9 recall p3", tap(3), 6'h01);
    check(busy == 1'b0, "R9 busy low after reset", busy, 0);
    do_read(ADDR, 8'hB6, ra, rd);
    check(rd == 8'h15, "R6 slot retained over reset", rd, 8'h15);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule